// File: doc/BRIEF.md
# Clock Modulation Duty Controller

This block throttles the clocks of a group of cores. For each core it produces a clock-enable that is high for the first part of a repeating 16-cycle window and low for the rest, so a downstream gating cell passes only a programmed fraction of the core clock. Three sources can ask for throttling. Each core has its own modulation register. A single legacy register, written through an emulated I/O path, throttles every core at once. A thermal-engage input applies a duty that is fixed when the block is built.

The sources are resolved per core by fixed priority. The thermal request wins over everything. The legacy request wins over a core's own register. A strap input picks the duty step size: coarse steps of 2/16 (12.5%) or fine steps of 1/16 (6.25%). Each core's resolved duty is latched only at a window boundary, so the output never shows a truncated or mixed pattern. Software writes the registers through a simple write port, one write per cycle.

Top module: `clkmod_duty_ctrl`

## Requirements
- R1: After synchronous reset every core's enable is high in all cycles of the window, the window counter starts at position 0 in the first cycle after reset is released, and each register is cleared.
- R2: A modulation register value has bit 4 as enable and bits [3:1] as duty. With the strap low (coarse steps), an enabled core with duty d in 1..7 is enabled for 2*d cycles of each 16-cycle window.
- R3: With the strap high (fine steps), bits [3:0] form the duty d, and an enabled source with d in 1..15 gives d enabled cycles per window.
- R4: Within each 16-cycle window the enable is high for a contiguous run that starts at window position 0, then low until the window ends.
- R5: A source whose enable bit is 0, or whose duty code under the current step size is 0, requests nothing. A core with no active request is enabled for all 16 cycles.
- R6: An active legacy request overrides the core's own register. A legacy request with a zero code does not hide an active core register.
- R7: While the thermal-engage input is high at a window boundary, every core uses the built-in thermal duty (parameter TCC_ON_CYCLES, default 10 of 16), whatever the other sources request.
- R8: A write to one core's register changes only that core's pattern. The legacy register applies to all cores.
- R9: Register writes, strap changes and thermal-engage changes take effect only from the next window boundary. The window in progress keeps its pattern.
- R10: With coarse steps, bit 0 of a register value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fine_step_i | input | 1 | Step-size strap: 1 = 1/16 steps, 0 = 2/16 steps |
| reg_wr_en_i | input | 1 | Write strobe for a per-core modulation register |
| reg_wr_core_i | input | CORE_W | Index of the core register being written |
| reg_wr_data_i | input | 5 | Per-core register value: bit 4 enable, bits [3:0] duty field |
| io_wr_en_i | input | 1 | Write strobe for the legacy all-core register |
| io_wr_data_i | input | 5 | Legacy register value, same layout as the per-core value |
| tcc_engage_i | input | 1 | Thermal control request, applies the built-in duty |
| gate_en_o | output | NUM_CORES | Per-core clock enable |

## Verification
The hardest case to reach from the ports is a change of request in the middle of a window. The output must keep the old pattern until the boundary and then switch cleanly. The bench tracks the window position from reset release. It issues a register write at position 7 while it is still sampling the window, checks that this window keeps the old count, and checks that the next window shows the new one. Overlapping sources are built up in layers, a core register under a legacy request under a thermal engage. Each layer is then removed to confirm that the one below it comes back.

// File: rtl/clkmod_pkg.sv
// Package: shared widths and the modulation register layout.
// Assumes the window length is tied to the 4-bit fine duty field.
package clkmod_pkg;
    localparam int DUTY_W  = 4;               // full duty field width
    localparam int WIN_LEN = 2 ** DUTY_W;     // cycles per modulation window
    localparam int ON_W    = DUTY_W + 1;      // holds 0..WIN_LEN
    localparam int REG_W   = DUTY_W + 1;      // enable bit + duty field

    // Register value: en at bit 4, duty field at bits [3:0]
    typedef struct packed {
        logic              en;
        logic [DUTY_W-1:0] code;
    } modreg_t;
endpackage

// File: rtl/clkmod_src_decode.sv
// Module: turns one modulation register value into an active flag and
// a count of enabled cycles per window. Coarse mode uses bits [3:1]
// as a count of 2-cycle steps; fine mode uses bits [3:0] as 1-cycle steps.
// Assumes: a zero step count is reserved and means "no request".
module clkmod_src_decode
    import clkmod_pkg::*;
(
    input  logic            fine_i,
    input  modreg_t         reg_i,
    output logic            active_o,
    output logic [ON_W-1:0] on_o
);
    logic [DUTY_W-1:0] steps;

    // Scale the duty field to enabled cycles for the selected step size
    always_comb begin
        steps    = fine_i ? reg_i.code : {reg_i.code[DUTY_W-1:1], 1'b0};
        active_o = reg_i.en && (steps != '0);
        on_o     = active_o ? {1'b0, steps} : ON_W'(WIN_LEN);
    end
endmodule

// File: rtl/clkmod_window_ctr.sv
// Module: free-running window position counter shared by all cores.
// Assumes: the window length is a power of two, so the counter wraps by itself.
module clkmod_window_ctr
    import clkmod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [DUTY_W-1:0] cnt_o,
    output logic              last_o
);
    // Advance the window position every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= cnt_o + 1'b1;
    end

    // Flag the final cycle of the window
    assign last_o = (cnt_o == {DUTY_W{1'b1}});

    p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (cnt_o == '0));
endmodule

// File: rtl/clkmod_core_gate.sv
// Module: per-core arbitration and pattern generation. Thermal beats
// legacy, legacy beats the core register, otherwise full enable. The
// winner is latched only on the last window cycle.
// Assumes: TCC_ON_CYCLES is in 1..WIN_LEN.
module clkmod_core_gate
    import clkmod_pkg::*;
#(
    parameter int TCC_ON_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_i,
    input  logic [DUTY_W-1:0] cnt_i,
    input  logic              tcc_i,
    input  logic              io_act_i,
    input  logic [ON_W-1:0]   io_on_i,
    input  logic              reg_act_i,
    input  logic [ON_W-1:0]   reg_on_i,
    output logic              gate_o
);
    localparam logic [ON_W-1:0] TCC_ON  = ON_W'(TCC_ON_CYCLES);
    localparam logic [ON_W-1:0] FULL_ON = ON_W'(WIN_LEN);

    logic [ON_W-1:0] sel_on;
    logic [ON_W-1:0] on_q;

    // Pick the winning source's cycle count by fixed priority
    always_comb begin
        if (tcc_i)          sel_on = TCC_ON;
        else if (io_act_i)  sel_on = io_on_i;
        else if (reg_act_i) sel_on = reg_on_i;
        else                sel_on = FULL_ON;
    end

    // Load the next window's count only at the window boundary
    always_ff @(posedge clk) begin
        if (!rst_n)      on_q <= FULL_ON;
        else if (last_i) on_q <= sel_on;
    end

    // Enable for the leading on_q cycles of the window
    assign gate_o = ({1'b0, cnt_i} < on_q);

    p_hold_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !last_i |=> $stable(on_q));
    p_tcc_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && tcc_i) |=> (on_q == TCC_ON));
    p_io_over_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && !tcc_i && io_act_i) |=> (on_q == $past(io_on_i)));
    p_idle_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_i && !tcc_i && !io_act_i && !reg_act_i) |=> (on_q == FULL_ON));
endmodule

// File: rtl/clkmod_duty_ctrl.sv
// Module: top of the clock modulation duty controller. Holds the
// per-core and legacy registers, decodes them, and drives one
// enable per core from a shared window counter.
// Assumes: NUM_CORES >= 2; one register write per port per cycle.
module clkmod_duty_ctrl
    import clkmod_pkg::*;
#(
    parameter int NUM_CORES     = 4,
    parameter int TCC_ON_CYCLES = 10,
    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fine_step_i,
    input  logic                 reg_wr_en_i,
    input  logic [CORE_W-1:0]    reg_wr_core_i,
    input  logic [REG_W-1:0]     reg_wr_data_i,
    input  logic                 io_wr_en_i,
    input  logic [REG_W-1:0]     io_wr_data_i,
    input  logic                 tcc_engage_i,
    output logic [NUM_CORES-1:0] gate_en_o
);
    modreg_t           io_reg_q;
    logic              io_act;
    logic [ON_W-1:0]   io_on;
    logic [DUTY_W-1:0] win_cnt;
    logic              win_last;

    // Legacy register shared by all cores
    always_ff @(posedge clk) begin
        if (!rst_n)          io_reg_q <= '0;
        else if (io_wr_en_i) io_reg_q <= modreg_t'(io_wr_data_i);
    end

    clkmod_src_decode u_io_dec (
        .fine_i   (fine_step_i),
        .reg_i    (io_reg_q),
        .active_o (io_act),
        .on_o     (io_on)
    );

    clkmod_window_ctr u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (win_cnt),
        .last_o (win_last)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        modreg_t         core_reg_q;
        logic            reg_act;
        logic [ON_W-1:0] reg_on;

        // Per-core register, written when the index selects this core
        always_ff @(posedge clk) begin
            if (!rst_n)
                core_reg_q <= '0;
            else if (reg_wr_en_i && (reg_wr_core_i == CORE_W'(c)))
                core_reg_q <= modreg_t'(reg_wr_data_i);
        end

        clkmod_src_decode u_dec (
            .fine_i   (fine_step_i),
            .reg_i    (core_reg_q),
            .active_o (reg_act),
            .on_o     (reg_on)
        );

        clkmod_core_gate #(.TCC_ON_CYCLES(TCC_ON_CYCLES)) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .last_i    (win_last),
            .cnt_i     (win_cnt),
            .tcc_i     (tcc_engage_i),
            .io_act_i  (io_act),
            .io_on_i   (io_on),
            .reg_act_i (reg_act),
            .reg_on_i  (reg_on),
            .gate_o    (gate_en_o[c])
        );

        p_no_regate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!gate_en_o[c] && !win_last) |=> !gate_en_o[c]);
    end

    p_window_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt == '0) |-> (&gate_en_o));
endmodule

// File: tb/clkmod_duty_ctrl_tb_top.sv
module clkmod_duty_ctrl_tb_top;
    localparam int NC  = 4;
    localparam int TCC = 10;
    localparam int WIN = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fine_step_i = 1'b0;
    logic          reg_wr_en_i = 1'b0;
    logic [1:0]    reg_wr_core_i = '0;
    logic [4:0]    reg_wr_data_i = '0;
    logic          io_wr_en_i = 1'b0;
    logic [4:0]    io_wr_data_i = '0;
    logic          tcc_engage_i = 1'b0;
    logic [NC-1:0] gate_en_o;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    int meas_on[NC];
    bit meas_shape[NC];

    always #5 clk = ~clk;

    clkmod_duty_ctrl #(.NUM_CORES(NC), .TCC_ON_CYCLES(TCC)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fine_step_i   (fine_step_i),
        .reg_wr_en_i   (reg_wr_en_i),
        .reg_wr_core_i (reg_wr_core_i),
        .reg_wr_data_i (reg_wr_data_i),
        .io_wr_en_i    (io_wr_en_i),
        .io_wr_data_i  (io_wr_data_i),
        .tcc_engage_i  (tcc_engage_i),
        .gate_en_o     (gate_en_o)
    );

    // Window position model: counts edges since reset release (R1)
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic core_wr(int core, logic [4:0] val);
        reg_wr_en_i = 1'b1; reg_wr_core_i = 2'(core); reg_wr_data_i = val;
        @(negedge clk);
        reg_wr_en_i = 1'b0;
    endtask

    task automatic io_wr(logic [4:0] val);
        io_wr_en_i = 1'b1; io_wr_data_i = val;
        @(negedge clk);
        io_wr_en_i = 1'b0;
    endtask

    // Sample one full window; optional write to core wcore at position wpos
    task automatic sample_win(int wpos, int wcore, logic [4:0] wval);
        bit seen_low[NC];
        @(negedge clk);
        while (cyc % WIN != 0) @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            meas_on[c] = 0; meas_shape[c] = 1; seen_low[c] = 0;
        end
        for (int k = 0; k < WIN; k++) begin
            for (int c = 0; c < NC; c++) begin
                if (gate_en_o[c]) begin
                    meas_on[c]++;
                    if (seen_low[c]) meas_shape[c] = 0;
                end else seen_low[c] = 1;
            end
            if (k == wpos) begin
                reg_wr_en_i = 1'b1; reg_wr_core_i = 2'(wcore); reg_wr_data_i = wval;
            end else reg_wr_en_i = 1'b0;
            if (k != WIN - 1) @(negedge clk);
        end
        reg_wr_en_i = 1'b0;
    endtask

    task automatic expect_win(string req, int exp[NC]);
        for (int c = 0; c < NC; c++) begin
            chk($sformatf("%s core%0d count", req, c), meas_on[c], exp[c]);
            chk($sformatf("R4 core%0d contiguous (%s)", c, req), int'(meas_shape[c]), 1);
        end
    endtask

    task automatic t_reset();
        sample_win(-1, 0, '0);
        expect_win("R1 reset", '{16, 16, 16, 16});
    endtask

    task automatic t_coarse();
        core_wr(0, 5'b1_011_0);
        core_wr(3, 5'b1_111_0);
        sample_win(-1, 0, '0);
        expect_win("R2/R8 coarse per core", '{6, 16, 16, 14});
    endtask

    task automatic t_coarse_bit0();
        core_wr(0, 5'b1_011_1);
        sample_win(-1, 0, '0);
        expect_win("R10 bit0 ignored", '{6, 16, 16, 14});
        core_wr(3, 5'b0_000_0);
    endtask

    task automatic t_fine();
        fine_step_i = 1'b1;
        core_wr(2, 5'b1_0001);
        sample_win(-1, 0, '0);
        expect_win("R3 fine steps", '{7, 16, 1, 16});
        fine_step_i = 1'b0;
        sample_win(-1, 0, '0);
        expect_win("R5 coarse zero code", '{6, 16, 16, 16});
    endtask

    task automatic t_zero();
        core_wr(1, 5'b1_000_0);
        sample_win(-1, 0, '0);
        expect_win("R5 enabled zero", '{6, 16, 16, 16});
        core_wr(1, 5'b0_101_0);
        sample_win(-1, 0, '0);
        expect_win("R5 disabled", '{6, 16, 16, 16});
    endtask

    task automatic t_io();
        io_wr(5'b1_010_0);
        sample_win(-1, 0, '0);
        expect_win("R6/R8 legacy all cores", '{4, 4, 4, 4});
        io_wr(5'b1_000_0);
        sample_win(-1, 0, '0);
        expect_win("R6 legacy zero code", '{6, 16, 16, 16});
    endtask

    task automatic t_tcc();
        io_wr(5'b1_010_0);
        tcc_engage_i = 1'b1;
        sample_win(-1, 0, '0);
        expect_win("R7 thermal override", '{TCC, TCC, TCC, TCC});
        tcc_engage_i = 1'b0;
        sample_win(-1, 0, '0);
        expect_win("R7 thermal released", '{4, 4, 4, 4});
        io_wr(5'b0_000_0);
        sample_win(-1, 0, '0);
        expect_win("R6 legacy cleared", '{6, 16, 16, 16});
    endtask

    task automatic t_boundary();
        sample_win(7, 0, 5'b1_001_0);
        expect_win("R9 window in progress", '{6, 16, 16, 16});
        sample_win(-1, 0, '0);
        expect_win("R9 next window", '{2, 16, 16, 16});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_coarse();
        t_coarse_bit0();
        t_fine();
        t_zero();
        t_io();
        t_tcc();
        t_boundary();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule